// File: doc/BRIEF.md
# Collision-Mode Dual-Port RAM

This block is a single-clock memory with one write port and two independent read ports. Each read port has its own enable and address and can look at any word, including the word the write port is storing in that same cycle. Two elaboration-time choices define it. The first selects what a registered read returns when its address matches the write address: the stored content before the write, the data being written, or no update at all while a write is in progress. The second selects whether read data comes from a register after the clock edge, or straight from the array through combinational logic.

It serves as a local scratch store inside a datapath. One producer writes through the write port. Two consumers read at their own addresses, for example the two operands of an arithmetic unit. The collision mode is chosen to match what the surrounding pipeline expects when it reads a word that is being written in the same cycle.

Top module: `collide_ram`

## Requirements
- R1: When `wr_en` is high at a rising edge of `clk`, `wr_data` is stored at word `wr_addr`. A later read of that word returns it until the word is written again.
- R2: The two read ports work independently. In the same cycle each can read a different word, and each returns the content of its own address.
- R3: In mode `COLL_OLD` (MODE value 0), a registered read whose address equals `wr_addr` while `wr_en` is high returns the word's content from before that write.
- R4: In mode `COLL_NEW` (MODE value 1), a registered read whose address equals `wr_addr` while `wr_en` is high returns the `wr_data` of that same cycle.
- R5: In mode `COLL_HOLD` (MODE value 2), both registered read outputs keep their value through every cycle in which `wr_en` is high, whatever the addresses.
- R6: In mode `COLL_HOLD`, a word written under a hold is returned by a read issued in a later cycle with `wr_en` low.
- R7: With `SYNC_READ`=1, a read enabled at a rising edge updates that port's data output at that same edge, which is a latency of one clock.
- R8: With `SYNC_READ`=1, a port whose enable is low at a rising edge keeps its data output unchanged.
- R9: With `SYNC_READ`=0, each data output is always the current array content at that port's address. The enables and MODE have no effect, and a write is visible as soon as the edge that stores it has passed.
- R10: While `rst_n` is low, the registered read outputs are zero. The reset is asynchronous and active low. The array contents are not reset.
- R11: DEPTH and WIDTH are parameters, and the address width is ceil(log2(DEPTH)). The lowest and highest words are separate locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every write and every registered read happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read output registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word written when `wr_en` is high |
| wr_data | input | WIDTH | Data to store |
| rd0_en | input | 1 | Read enable, port 0 (registered reads only) |
| rd0_addr | input | AW | Read address, port 0 |
| rd0_data | output | WIDTH | Read data, port 0 |
| rd1_en | input | 1 | Read enable, port 1 (registered reads only) |
| rd1_addr | input | AW | Read address, port 1 |
| rd1_data | output | WIDTH | Read data, port 1 |

## Verification
The case that matters is a write and a read of the same word at the same clock edge, on either read port or on both. A directed sequence writes word 5 while both ports read word 5 and then reads it again with no write. A long random phase follows in which half of all addresses come from a four-word window, so that same-word hits and two-port overlaps happen often. Four instances share the stimulus, one for each collision mode plus a combinational-read build. A behavioural model updates its shadow array after it has computed each port's result, and it is compared with every output on every clock.

// File: rtl/collide_ram_pkg.sv
package collide_ram_pkg;

    // What a registered read returns when it meets the write address
    typedef enum logic [1:0] {
        COLL_OLD  = 2'd0,   // content before the write
        COLL_NEW  = 2'd1,   // data being written
        COLL_HOLD = 2'd2    // output frozen while any write is active
    } coll_mode_e;

    localparam int NUM_RD = 2;

endpackage

// File: rtl/collide_ram_store.sv
module collide_ram_store
    import collide_ram_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic [NUM_RD-1:0][AW-1:0]     rd_addr,
    output logic [NUM_RD-1:0][WIDTH-1:0]  rd_word
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // One combinational tap per read port
    for (genvar p = 0; p < NUM_RD; p++) begin : g_tap
        assign rd_word[p] = mem_q[rd_addr[p]];
    end

endmodule

// File: rtl/collide_ram_rport.sv
module collide_ram_rport
    import collide_ram_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter int         AW        = 4,
    parameter coll_mode_e MODE      = COLL_OLD,
    parameter bit         SYNC_READ = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [WIDTH-1:0] arr_word,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    typedef struct packed {
        logic [WIDTH-1:0] dout;
    } rport_st_t;

    rport_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit  = rd_en && wr_en && (rd_addr == wr_addr);
        st_d = st_q;
        case (MODE)
            COLL_OLD: begin
                if (rd_en) st_d.dout = arr_word;
            end
            COLL_NEW: begin
                if (rd_en) st_d.dout = hit ? wr_data : arr_word;
            end
            default: begin
                if (rd_en && !wr_en) st_d.dout = arr_word;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = SYNC_READ ? st_q.dout : arr_word;

endmodule

// File: rtl/collide_ram.sv
module collide_ram
    import collide_ram_pkg::*;
#(
    parameter int         DEPTH     = 16,
    parameter int         WIDTH     = 8,
    parameter coll_mode_e MODE      = COLL_OLD,
    parameter bit         SYNC_READ = 1'b1,
    localparam int        AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd0_en,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    input  logic             rd1_en,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data
);

    logic [NUM_RD-1:0]            en_v;
    logic [NUM_RD-1:0][AW-1:0]    addr_v;
    logic [NUM_RD-1:0][WIDTH-1:0] word_v;
    logic [NUM_RD-1:0][WIDTH-1:0] data_v;

    assign en_v     = {rd1_en, rd0_en};
    assign addr_v   = {rd1_addr, rd0_addr};
    assign rd0_data = data_v[0];
    assign rd1_data = data_v[1];

    collide_ram_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_v),
        .rd_word (word_v)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        collide_ram_rport #(
            .WIDTH     (WIDTH),
            .AW        (AW),
            .MODE      (MODE),
            .SYNC_READ (SYNC_READ)
        ) u_rport (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (en_v[p]),
            .rd_addr  (addr_v[p]),
            .arr_word (word_v[p]),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .rd_data  (data_v[p])
        );
    end

endmodule

// File: rtl/collide_ram_chk.sv
module collide_ram_chk
    import collide_ram_pkg::*;
#(
    parameter int         DEPTH     = 16,
    parameter int         WIDTH     = 8,
    parameter coll_mode_e MODE      = COLL_OLD,
    parameter bit         SYNC_READ = 1'b1,
    localparam int        AW        = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd0_en,
    input logic [AW-1:0]    rd0_addr,
    input logic [WIDTH-1:0] rd0_data,
    input logic             rd1_en,
    input logic [AW-1:0]    rd1_addr,
    input logic [WIDTH-1:0] rd1_data
);

    if (SYNC_READ) begin : g_sync
        // R8: an idle port keeps its output
        p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rd0_en) |-> $stable(rd0_data));
        p_idle_hold1_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rd1_en) |-> $stable(rd1_data));

        // R1: write, then a clean read one cycle later returns it
        p_wr_then_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en, 2) && !$past(wr_en) && $past(rd0_en)
             && $past(rd0_addr) == $past(wr_addr, 2))
            |-> rd0_data == $past(wr_data, 2));
        p_wr_then_rd1_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en, 2) && !$past(wr_en) && $past(rd1_en)
             && $past(rd1_addr) == $past(wr_addr, 2))
            |-> rd1_data == $past(wr_data, 2));

        if (MODE == COLL_OLD) begin : g_old
            // R3: a hit returns what the previous write stored
            p_old_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(wr_en, 2) && $past(wr_en) && $past(rd0_en)
                 && $past(rd0_addr) == $past(wr_addr)
                 && $past(wr_addr, 2) == $past(wr_addr))
                |-> rd0_data == $past(wr_data, 2));
        end else if (MODE == COLL_NEW) begin : g_new
            // R4: a hit returns the incoming data
            p_new_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wr_en && rd0_en && rd0_addr == wr_addr)
                |-> rd0_data == $past(wr_data));
        end else begin : g_hold
            // R5: any write freezes both outputs
            p_freeze_on_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wr_en) |-> ($stable(rd0_data) && $stable(rd1_data)));
        end
    end else begin : g_async
        // R9: a write is visible right after its edge
        p_async_sees_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && rd0_addr == $past(wr_addr))
            |-> rd0_data == $past(wr_data));
        p_async_sees_wr1_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && rd1_addr == $past(wr_addr))
            |-> rd1_data == $past(wr_data));
    end

endmodule

bind collide_ram collide_ram_chk #(
    .DEPTH     (DEPTH),
    .WIDTH     (WIDTH),
    .MODE      (MODE),
    .SYNC_READ (SYNC_READ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd0_en   (rd0_en),
    .rd0_addr (rd0_addr),
    .rd0_data (rd0_data),
    .rd1_en   (rd1_en),
    .rd1_addr (rd1_addr),
    .rd1_data (rd1_data)
);

// File: tb/test_collide_ram.sv
module test_collide_ram;
    import collide_ram_pkg::*;

    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int NDUT  = 4;   // 0 old, 1 new, 2 hold, 3 combinational

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             en0 = 1'b0, en1 = 1'b0;
    logic [AW-1:0]    a0 = '0, a1 = '0;
    logic [WIDTH-1:0] dout [NDUT][2];

    int     n_cmp = 0, n_bad = 0;
    bit     cmp_on = 1'b0;
    bit     done = 1'b0;
    string  ph = "R10";

    always #2 clk = ~clk;   // 250 MHz

    collide_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(COLL_OLD), .SYNC_READ(1'b1)) i_collide_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(en0), .rd0_addr(a0), .rd0_data(dout[0][0]),
        .rd1_en(en1), .rd1_addr(a1), .rd1_data(dout[0][1]));
    collide_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(COLL_NEW), .SYNC_READ(1'b1)) i_collide_ram_new (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(en0), .rd0_addr(a0), .rd0_data(dout[1][0]),
        .rd1_en(en1), .rd1_addr(a1), .rd1_data(dout[1][1]));
    collide_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(COLL_HOLD), .SYNC_READ(1'b1)) i_collide_ram_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(en0), .rd0_addr(a0), .rd0_data(dout[2][0]),
        .rd1_en(en1), .rd1_addr(a1), .rd1_data(dout[2][1]));
    collide_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(COLL_OLD), .SYNC_READ(1'b0)) i_collide_ram_comb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(en0), .rd0_addr(a0), .rd0_data(dout[3][0]),
        .rd1_en(en1), .rd1_addr(a1), .rd1_data(dout[3][1]));

    // Behavioural reference model
    logic [WIDTH-1:0] mem_m [DEPTH];
    logic [WIDTH-1:0] q_m [3][2];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
        for (int d = 0; d < 3; d++) begin
            q_m[d][0] = '0;
            q_m[d][1] = '0;
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            logic          en;
            logic [AW-1:0] a;
            en = (p == 0) ? en0 : en1;
            a  = (p == 0) ? a0 : a1;
            if (!rst_n) begin
                for (int d = 0; d < 3; d++) q_m[d][p] = '0;
            end else if (en) begin
                q_m[0][p] = mem_m[a];
                q_m[1][p] = (wr_en && a == wr_addr) ? wr_data : mem_m[a];
                if (!wr_en) q_m[2][p] = mem_m[a];
            end
        end
        if (wr_en) mem_m[wr_addr] = wr_data;
    end

    function automatic string dut_tag(int d);
        case (d)
            0:       return "R3 old-data";
            1:       return "R4 new-data";
            2:       return "R5 hold";
            default: return "R9 combinational";
        endcase
    endfunction

    task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int d = 0; d < NDUT; d++) begin
            for (int p = 0; p < 2; p++) begin
                logic [WIDTH-1:0] exp;
                exp = (d < 3) ? q_m[d][p] : mem_m[(p == 0) ? a0 : a1];
                check($sformatf("%s [%s] port%0d", ph, dut_tag(d), p), dout[d][p], exp);
            end
        end
    endtask

    // One clock: pass the edge, then compare away from it
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (cmp_on) compare_all();
    endtask

    task automatic drive(bit we, int wa, int wd, bit e0, int r0, bit e1, int r1);
        wr_en   = we;
        wr_addr = AW'(wa);
        wr_data = WIDTH'(wd);
        en0 = e0; a0 = AW'(r0);
        en1 = e1; a1 = AW'(r1);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R10: registered outputs cleared under reset
        repeat (3) @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            check("R10 reset port0", dout[d][0], '0);
            check("R10 reset port1", dout[d][1], '0);
        end
        rst_n = 1'b1;

        // R1: fill every word with reads idle
        ph = "R1 fill";
        for (int i = 0; i < DEPTH; i++) drive(1, i, 8'h40 + i * 7, 0, 0, 0, 0);
        cmp_on = 1'b1;
        ph = "R1 readback";
        for (int i = 0; i < DEPTH; i++) drive(0, 0, 0, 1, i, 1, DEPTH - 1 - i);

        // R2: independent addresses on both ports
        ph = "R2 independent";
        drive(0, 0, 0, 1, 3, 1, 12);
        drive(0, 0, 0, 1, 12, 1, 3);
        drive(0, 0, 0, 1, 7, 1, 7);

        // R7: one-clock latency, address changing every cycle
        ph = "R7 latency";
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, i, 1, i + 8);

        // R8: enables low while addresses move
        ph = "R8 idle hold";
        drive(0, 0, 0, 0, 1, 0, 2);
        drive(0, 0, 0, 0, 9, 0, 10);
        drive(0, 0, 0, 1, 9, 0, 10);

        // R3/R4/R5: write word 5 while both ports read word 5
        ph = "R3 R4 R5 collision";
        drive(1, 5, 8'hA5, 1, 5, 1, 5);
        drive(1, 5, 8'h5A, 1, 5, 1, 6);
        // R5: a write elsewhere still freezes the hold build
        drive(1, 2, 8'hC3, 1, 5, 1, 9);
        // R6: clean read afterwards exposes the new content
        ph = "R6 read after hold";
        drive(0, 0, 0, 1, 5, 1, 2);

        // R11: extreme words are separate locations
        ph = "R11 bounds";
        drive(1, 0, 8'h11, 0, 0, 0, 0);
        drive(1, DEPTH - 1, 8'hEE, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 1, DEPTH - 1);

        // Random traffic biased toward same-word hits
        ph = "R2 R3 R4 R5 R9 random";
        for (int i = 0; i < 3000; i++) begin
            int ra0, ra1, wa;
            wa  = ($urandom % 2) ? $urandom % 4 : $urandom % DEPTH;
            ra0 = ($urandom % 2) ? $urandom % 4 : $urandom % DEPTH;
            ra1 = ($urandom % 2) ? $urandom % 4 : $urandom % DEPTH;
            drive(($urandom % 3) != 0, wa, $urandom % 256,
                  ($urandom % 4) != 0, ra0, ($urandom % 4) != 0, ra1);
        end

        // R10: reset in mid-run clears the registered outputs again
        cmp_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            check("R10 mid-run reset port0", dout[d][0], '0);
            check("R10 mid-run reset port1", dout[d][1], '0);
        end
        finish_run();
    end

endmodule